// File: doc/BRIEF.md
# Serial Bus Host Transaction Controller

This block is the host end of a five-wire synchronous serial control bus: a serial clock, an active-low select, a command line from host to device, a reply line from device to host, and an active-low interrupt line from device to host. Local logic hands it one request at a time. A request carries a one-burst register address, a read/write flag, a byte count and up to `MAX_BYTES` bytes of write data. The controller then runs one select period on the bus, made of one address burst followed by the data bursts. It returns any read data together with a one-cycle done strobe.

The serial clock is made by dividing the system clock by `DIV` (32 by default). The clock idles high. Each bit cell begins with a falling edge, at which the command line changes, and the reply line is sampled on the rising edge in the middle of the cell. After every select period, a programmable number of system cycles must pass with select high before another request is taken. An abort input ends an active transaction at once. The interrupt line passes through a multi-flop synchroniser and is presented as an active-high level flag.

Top module: `sbus_host`

## Requirements
- R1: After reset, `bus_csn`=1, `bus_sclk`=1, `bus_cmd`=0, `done`=0, `irq_flag`=0, `rd_data`=0 and `req_ready`=1.
- R2: While select is low, the serial clock has a period of `DIV` system cycles: it is low for `DIV/2` cycles and then high for `DIV/2` cycles. It shows exactly `BURST_W*(1+n)` rising edges per transaction, where n is the effective byte count. Whenever select is high, the serial clock is high.
- R3: A request is accepted on a clock edge where `req_valid`=1, `req_ready`=1 and `abort`=0. Select falls on that edge and stays low for exactly `DIV/2 + BURST_W*(1+n)*DIV` system cycles. The first falling serial clock edge comes `DIV/2` cycles after select falls.
- R4: The command line carries `req_addr` first. For a write, it then carries the low n bytes of `req_wdata`, most significant byte first. Every burst is sent MSB first. For a read, the data bursts are all zeros. The command line changes only as the serial clock falls, and it is 0 whenever select is high.
- R5: For a read, the reply line is sampled at each rising serial clock edge after the address burst, MSB first. At done, `rd_data` holds the received bits in its low n*`BURST_W` bits, with zeros above them.
- R6: `done` is a one-cycle pulse in the first cycle after select returns high at the end of a completed transaction. A write leaves `rd_data` unchanged.
- R7: A byte count above `MAX_BYTES` is treated as `MAX_BYTES`. A count of 0 gives an address-only transaction of a single burst, and a read with count 0 returns `rd_data`=0.
- R8: Between two select periods, select stays high for at least `OFF_CYCLES` system cycles, and `req_ready` is 0 throughout that gap. A request that is already waiting is accepted so that the gap is exactly `OFF_CYCLES` cycles.
- R9: When `abort` is 1 during a transaction, select and the serial clock are high on the next cycle. No done pulse follows, `rd_data` is unchanged, and the off-time gap of R8 applies. When the controller is idle, `abort` has no visible effect.
- R10: `irq_flag` is the inverse of `bus_irqn` delayed by `SYNC_STAGES` system clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present; held until accepted |
| req_ready | output | 1 | Controller idle and the off-time gap has elapsed |
| req_addr | input | BURST_W | Register address, sent as the first burst |
| req_write | input | 1 | 1 = write, 0 = read |
| req_nbytes | input | CNT_W | Number of data bursts (0..MAX_BYTES, larger values are clamped) |
| req_wdata | input | DATA_W | Write data in the low n bytes |
| abort | input | 1 | Ends an active transaction without a done pulse |
| rd_data | output | DATA_W | Read data from the last completed read |
| done | output | 1 | One-cycle completion strobe |
| bus_sclk | output | 1 | Serial clock, idles high |
| bus_csn | output | 1 | Active-low select |
| bus_cmd | output | 1 | Command line to the device |
| bus_reply | input | 1 | Reply line from the device |
| bus_irqn | input | 1 | Active-low interrupt from the device |
| irq_flag | output | 1 | Synchronised active-high interrupt flag |

## Verification
On every cycle, the assertions check the following: the serial clock stays high while select is high; the command line holds still while the serial clock is high; done appears only on the cycle that select rises; an abort releases select on the next cycle; the off-time gap is never shorter than `OFF_CYCLES`; the ready output stays low while select is low; and an interrupt flag rising is always preceded by a low interrupt input. Some behaviours need the bench scenarios instead, because they depend on the whole request and not on one cycle. These are the exact bit order on the command line for every byte count and direction, the value assembled in `rd_data`, the clamping of oversized counts, the exact select-low and serial-clock-low durations, and the gap measured after both normal completion and abort.

// File: rtl/sbus_host_pkg.sv
package sbus_host_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_LEAD  = 2'd1,
      ST_SHIFT = 2'd2
   } sbus_state_e;

endpackage

// File: rtl/sbus_phase_gen.sv
module sbus_phase_gen #(
   parameter int DIV = 32
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic run,
   output logic half_tick,
   output logic wrap_tick
);
   localparam int PH_W = $clog2(DIV);
   localparam int HALF = DIV / 2;

   if (DIV < 4 || (DIV % 2) != 0) begin : g_bad_div
      $error("sbus_phase_gen: DIV must be even and at least 4");
   end

   logic [PH_W-1:0] ph;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph <= '0;
      end else if (clear) begin
         ph <= '0;
      end else if (run) begin
         ph <= wrap_tick ? '0 : ph + PH_W'(1);
      end
   end

   assign half_tick = (ph == PH_W'(HALF - 1));
   assign wrap_tick = (ph == PH_W'(DIV - 1));

endmodule

// File: rtl/sbus_gap_timer.sv
module sbus_gap_timer #(
   parameter int OFF_CYCLES = 20
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm,
   output logic open
);
   localparam int CNT_W = (OFF_CYCLES < 2) ? 1 : $clog2(OFF_CYCLES);

   if (OFF_CYCLES < 1) begin : g_bad_off
      $error("sbus_gap_timer: OFF_CYCLES must be at least 1");
   end

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (arm) begin
         cnt <= CNT_W'(OFF_CYCLES - 1);
      end else if (cnt != '0) begin
         cnt <= cnt - CNT_W'(1);
      end
   end

   assign open = (cnt == '0);

endmodule

// File: rtl/sbus_irq_sync.sv
module sbus_irq_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic irq_n,
   output logic irq_flag
);
   if (STAGES < 2) begin : g_bad_stages
      $error("sbus_irq_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] stage_q;

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      logic d_in;
      if (g == 0) begin : g_first
         assign d_in = irq_n;
      end else begin : g_next
         assign d_in = stage_q[g-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            stage_q[g] <= 1'b1;
         end else begin
            stage_q[g] <= d_in;
         end
      end
   end

   assign irq_flag = ~stage_q[STAGES-1];

endmodule

// File: rtl/sbus_host.sv
module sbus_host
   import sbus_host_pkg::*;
#(
   parameter int DIV         = 32,
   parameter int MAX_BYTES   = 4,
   parameter int BURST_W     = 8,
   parameter int OFF_CYCLES  = 20,
   parameter int SYNC_STAGES = 2,
   localparam int DATA_W     = MAX_BYTES * BURST_W,
   localparam int CNT_W      = $clog2(MAX_BYTES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [BURST_W-1:0] req_addr,
   input  logic              req_write,
   input  logic [CNT_W-1:0]  req_nbytes,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic              abort,
   output logic [DATA_W-1:0] rd_data,
   output logic              done,
   output logic              bus_sclk,
   output logic              bus_csn,
   output logic              bus_cmd,
   input  logic              bus_reply,
   input  logic              bus_irqn,
   output logic              irq_flag
);
   localparam int TX_W  = (MAX_BYTES + 1) * BURST_W;
   localparam int BIT_W = $clog2(TX_W);

   if (MAX_BYTES < 1) begin : g_bad_bytes
      $error("sbus_host: MAX_BYTES must be at least 1");
   end
   if (BURST_W < 2) begin : g_bad_burst
      $error("sbus_host: BURST_W must be at least 2");
   end

   sbus_state_e       state;
   logic [TX_W-1:0]   tx_sh;
   logic [DATA_W-1:0] rx_sh;
   logic [DATA_W-1:0] rd_q;
   logic [BIT_W-1:0]  bit_idx;
   logic [BIT_W-1:0]  last_bit;
   logic              is_write;
   logic              sclk_q, csn_q, cmd_q, done_q;

   logic              half_tick, wrap_tick, gap_open;
   logic              busy, accept, kill, lead_end, fin, data_phase;
   logic [CNT_W-1:0]  nb_eff;
   logic [DATA_W-1:0] wr_aligned;

   // byte count clamp and write data alignment (first byte sent sits at the top)
   assign nb_eff     = (req_nbytes > CNT_W'(MAX_BYTES)) ? CNT_W'(MAX_BYTES) : req_nbytes;
   assign wr_aligned = req_wdata << (BURST_W * (MAX_BYTES - int'(nb_eff)));

   assign busy       = (state != ST_IDLE);
   assign req_ready  = (state == ST_IDLE) && gap_open;
   assign accept     = req_ready && req_valid && !abort;
   assign kill       = busy && abort;
   assign lead_end   = (state == ST_LEAD) && half_tick;
   assign fin        = (state == ST_SHIFT) && wrap_tick && (bit_idx == last_bit);
   assign data_phase = (bit_idx >= BIT_W'(BURST_W));

   sbus_phase_gen #(.DIV(DIV)) u_phase (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (accept || lead_end),
      .run       (busy),
      .half_tick (half_tick),
      .wrap_tick (wrap_tick)
   );

   sbus_gap_timer #(.OFF_CYCLES(OFF_CYCLES)) u_gap (
      .clk   (clk),
      .rst_n (rst_n),
      .arm   (fin || kill),
      .open  (gap_open)
   );

   sbus_irq_sync #(.STAGES(SYNC_STAGES)) u_irq (
      .clk      (clk),
      .rst_n    (rst_n),
      .irq_n    (bus_irqn),
      .irq_flag (irq_flag)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         tx_sh    <= '0;
         rx_sh    <= '0;
         rd_q     <= '0;
         bit_idx  <= '0;
         last_bit <= '0;
         is_write <= 1'b0;
         sclk_q   <= 1'b1;
         csn_q    <= 1'b1;
         cmd_q    <= 1'b0;
         done_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (kill) begin
            state  <= ST_IDLE;
            csn_q  <= 1'b1;
            sclk_q <= 1'b1;
            cmd_q  <= 1'b0;
         end else begin
            unique case (state)
               ST_IDLE: begin
                  if (accept) begin
                     state    <= ST_LEAD;
                     csn_q    <= 1'b0;
                     tx_sh    <= {req_addr, (req_write ? wr_aligned : DATA_W'(0))};
                     rx_sh    <= '0;
                     bit_idx  <= '0;
                     last_bit <= BIT_W'((int'(nb_eff) + 1) * BURST_W - 1);
                     is_write <= req_write;
                  end
               end
               ST_LEAD: begin
                  if (half_tick) begin
                     state  <= ST_SHIFT;
                     sclk_q <= 1'b0;
                     cmd_q  <= tx_sh[TX_W-1];
                     tx_sh  <= tx_sh << 1;
                  end
               end
               ST_SHIFT: begin
                  if (half_tick) begin
                     sclk_q <= 1'b1;
                     if (data_phase && !is_write) begin
                        rx_sh <= {rx_sh[DATA_W-2:0], bus_reply};
                     end
                  end
                  if (wrap_tick) begin
                     if (fin) begin
                        state  <= ST_IDLE;
                        csn_q  <= 1'b1;
                        cmd_q  <= 1'b0;
                        done_q <= 1'b1;
                        if (!is_write) begin
                           rd_q <= rx_sh;
                        end
                     end else begin
                        bit_idx <= bit_idx + BIT_W'(1);
                        sclk_q  <= 1'b0;
                        cmd_q   <= tx_sh[TX_W-1];
                        tx_sh   <= tx_sh << 1;
                     end
                  end
               end
               default: state <= ST_IDLE;
            endcase
         end
      end
   end

   assign bus_sclk = sclk_q;
   assign bus_csn  = csn_q;
   assign bus_cmd  = cmd_q;
   assign done     = done_q;
   assign rd_data  = rd_q;

endmodule

// File: rtl/sbus_host_chk.sv
module sbus_host_chk #(
   parameter int OFF_CYCLES  = 20,
   parameter int SYNC_STAGES = 2
) (
   input logic clk,
   input logic rst_n,
   input logic abort,
   input logic req_ready,
   input logic done,
   input logic bus_sclk,
   input logic bus_csn,
   input logic bus_cmd,
   input logic bus_irqn,
   input logic irq_flag
);
   localparam int HC_W = $clog2(OFF_CYCLES + 1) + 1;

   logic [HC_W-1:0] hi_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_cnt <= HC_W'(OFF_CYCLES);
      end else if (!bus_csn) begin
         hi_cnt <= '0;
      end else if (hi_cnt != HC_W'(OFF_CYCLES)) begin
         hi_cnt <= hi_cnt + HC_W'(1);
      end
   end

   // R2
   sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_csn |-> bus_sclk);

   // R4
   cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_csn && bus_sclk) |-> $stable(bus_cmd));

   // R6
   done_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (bus_csn && !$past(bus_csn)));

   // R8
   gap_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(bus_csn) |-> (hi_cnt == HC_W'(OFF_CYCLES)));

   // R8
   ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_csn |-> !req_ready);

   // R9
   abort_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (abort && !bus_csn) |=> (bus_csn && bus_sclk && !done));

   if (SYNC_STAGES == 2) begin : g_irq_chk
      logic [1:0] up_cnt;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            up_cnt <= '0;
         end else if (up_cnt != 2'd3) begin
            up_cnt <= up_cnt + 2'd1;
         end
      end
      // R10
      irq_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
         ((up_cnt >= 2'd2) && $rose(irq_flag)) |-> !$past(bus_irqn, 2));
   end

endmodule

bind sbus_host sbus_host_chk #(
   .OFF_CYCLES  (OFF_CYCLES),
   .SYNC_STAGES (SYNC_STAGES)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .abort     (abort),
   .req_ready (req_ready),
   .done      (done),
   .bus_sclk  (bus_sclk),
   .bus_csn   (bus_csn),
   .bus_cmd   (bus_cmd),
   .bus_irqn  (bus_irqn),
   .irq_flag  (irq_flag)
);

// File: tb/sbus_host_test.sv
module sbus_host_test;
   localparam int DIV  = 32;
   localparam int HALF = DIV / 2;
   localparam int MAXB = 4;
   localparam int BW   = 8;
   localparam int OFF  = 20;
   localparam int DW   = MAXB * BW;

   logic          clk, rst_n;
   logic          req_valid, req_ready, req_write, abort;
   logic [BW-1:0] req_addr;
   logic [2:0]    req_nbytes;
   logic [DW-1:0] req_wdata, rd_data;
   logic          done, bus_sclk, bus_csn, bus_cmd, bus_reply, bus_irqn, irq_flag;

   sbus_host #(.DIV(DIV), .MAX_BYTES(MAXB), .BURST_W(BW), .OFF_CYCLES(OFF), .SYNC_STAGES(2)) uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_addr(req_addr), .req_write(req_write), .req_nbytes(req_nbytes),
      .req_wdata(req_wdata), .abort(abort), .rd_data(rd_data), .done(done),
      .bus_sclk(bus_sclk), .bus_csn(bus_csn), .bus_cmd(bus_cmd),
      .bus_reply(bus_reply), .bus_irqn(bus_irqn), .irq_flag(irq_flag)
   );

   initial clk = 1'b0;
   always #5 clk = ~clk;

   int total = 0, fails = 0, cyc = 0;
   int lo_cnt = 0, sclk_lo = 0, hi_run = 0, last_gap = 0, done_cnt = 0;
   int rise_cnt = 0, fall_cnt = 0, rep_nb = 0;
   logic [63:0] cap = '0;
   logic [31:0] rep_word = '0;
   logic prev_csn = 1'b1;

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // device model: reply bits change on falling serial clock
   always @(negedge bus_csn) begin
      fall_cnt = 0; rise_cnt = 0; cap = '0;
   end
   always @(negedge bus_sclk) begin
      if (!bus_csn) begin
         if (fall_cnt >= BW && (rep_nb * BW - 1 - (fall_cnt - BW)) >= 0)
            bus_reply = rep_word[rep_nb * BW - 1 - (fall_cnt - BW)];
         else
            bus_reply = 1'b0;
         fall_cnt++;
      end
   end
   always @(posedge bus_sclk) begin
      if (!bus_csn) begin
         cap = {cap[62:0], bus_cmd};
         rise_cnt++;
      end
   end

   always @(negedge clk) begin
      cyc++;
      if (!bus_csn) begin
         lo_cnt++;
         if (!bus_sclk) sclk_lo++;
         if (prev_csn) last_gap = hi_run;
         hi_run = 0;
      end else begin
         hi_run++;
      end
      prev_csn = bus_csn;
      if (done) done_cnt++;
   end

   always @(posedge clk) begin
      if (cyc > 150000) begin
         total++; fails++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
         $display("%0d/%0d checks passed", total - fails, total);
         $finish;
      end
   end

   function automatic int eff_nb(input int n);
      return (n > MAXB) ? MAXB : n;
   endfunction

   function automatic logic [63:0] exp_cmd(input logic [7:0] a, input logic w, input int n, input logic [31:0] d);
      logic [63:0] v = 64'(a);
      for (int i = n - 1; i >= 0; i--) v = (v << 8) | (w ? 64'(d[i*8 +: 8]) : 64'd0);
      return v;
   endfunction

   task automatic launch(input logic [7:0] a, input logic w, input int n, input logic [31:0] d, input logic [31:0] rep);
      int t = 0;
      rep_word = rep; rep_nb = eff_nb(n);
      lo_cnt = 0; sclk_lo = 0; done_cnt = 0;
      req_addr = a; req_write = w; req_nbytes = 3'(n); req_wdata = d; req_valid = 1'b1;
      while (!req_ready && t < 2000) begin @(negedge clk); t++; end
      @(negedge clk);
      req_valid = 1'b0;
      chk(bus_csn == 1'b0, "R3 select falls on acceptance", 64'(bus_csn), 64'd0);
   endtask

   task automatic finish_check(input logic [7:0] a, input logic w, input int n, input logic [31:0] d,
                               input logic [31:0] rep, input logic [31:0] prev_rd, input bit check_gap);
      int t = 0;
      int ne = eff_nb(n);
      int nbits = (ne + 1) * BW;
      logic [63:0] mask = (64'd1 << nbits) - 64'd1;
      logic [63:0] rmask = (64'd1 << (ne * BW)) - 64'd1;
      while (done_cnt == 0 && t < 4000) begin @(negedge clk); t++; end
      repeat (2) @(negedge clk);
      chk(lo_cnt == HALF + nbits * DIV, "R3 select low duration", 64'(lo_cnt), 64'(HALF + nbits * DIV));
      chk(rise_cnt == nbits, "R2 rising serial clock edges", 64'(rise_cnt), 64'(nbits));
      chk(sclk_lo == nbits * HALF, "R2 serial clock low time", 64'(sclk_lo), 64'(nbits * HALF));
      chk((cap & mask) == exp_cmd(a, w, ne, d), "R4 command bit stream", cap & mask, exp_cmd(a, w, ne, d));
      if (!w) chk(rd_data == 32'(64'(rep) & rmask), "R5 read data", 64'(rd_data), 64'(rep) & rmask);
      else    chk(rd_data == prev_rd, "R6 write keeps read data", 64'(rd_data), 64'(prev_rd));
      chk(done_cnt == 1, "R6 single done pulse", 64'(done_cnt), 64'd1);
      chk(req_ready == 1'b0, "R8 ready low during gap", 64'(req_ready), 64'd0);
      if (n > MAXB) chk(rise_cnt == (MAXB + 1) * BW, "R7 byte count clamp", 64'(rise_cnt), 64'((MAXB + 1) * BW));
      if (n == 0)   chk(rise_cnt == BW, "R7 address-only burst", 64'(rise_cnt), 64'(BW));
      if (check_gap) chk(last_gap == OFF, "R8 select high gap", 64'(last_gap), 64'(OFF));
   endtask

   initial begin
      logic [31:0] prev_rd;
      bit first = 1'b1;
      rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_nbytes = '0;
      req_wdata = '0; abort = 1'b0; bus_reply = 1'b0; bus_irqn = 1'b1;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      chk(bus_csn == 1'b1, "R1 reset select", 64'(bus_csn), 64'd1);
      chk(bus_sclk == 1'b1, "R1 reset serial clock", 64'(bus_sclk), 64'd1);
      chk(bus_cmd == 1'b0, "R1 reset command line", 64'(bus_cmd), 64'd0);
      chk(done == 1'b0 && irq_flag == 1'b0, "R1 reset done and flag", 64'({done, irq_flag}), 64'd0);
      chk(rd_data == '0 && req_ready == 1'b1, "R1 reset data and ready", 64'({rd_data, req_ready}), 64'd1);

      // R10 interrupt synchroniser latency, both directions
      bus_irqn = 1'b0;
      @(negedge clk); chk(irq_flag == 1'b0, "R10 flag after one edge", 64'(irq_flag), 64'd0);
      @(negedge clk); chk(irq_flag == 1'b1, "R10 flag after two edges", 64'(irq_flag), 64'd1);
      bus_irqn = 1'b1;
      @(negedge clk); chk(irq_flag == 1'b1, "R10 release after one edge", 64'(irq_flag), 64'd1);
      @(negedge clk); chk(irq_flag == 1'b0, "R10 release after two edges", 64'(irq_flag), 64'd0);

      // sweep over direction and byte count, back to back
      prev_rd = rd_data;
      for (int w = 0; w < 2; w++) begin
         for (int k = 0; k < 6; k++) begin
            int n = (k == 5) ? 6 : k;
            logic [7:0]  a   = 8'(8'h5A + n * 23 + w * 100);
            logic [31:0] d   = 32'(32'h9E3779B9 * (n + 3 + w));
            logic [31:0] rep = 32'hC3A55A3C ^ (32'h01010101 * 32'(n + 1));
            launch(a, 1'(w), n, d, rep);
            finish_check(a, 1'(w), n, d, rep, prev_rd, !first);
            first = 1'b0;
            prev_rd = rd_data;
         end
      end

      // R9 abort in the middle of a read
      launch(8'hA7, 1'b0, 4, 32'h0, 32'h12345678);
      repeat (300) @(negedge clk);
      chk(bus_csn == 1'b0, "R9 transaction active before abort", 64'(bus_csn), 64'd0);
      abort = 1'b1;
      @(negedge clk);
      abort = 1'b0;
      chk(bus_csn == 1'b1 && bus_sclk == 1'b1, "R9 select and clock released", 64'({bus_csn, bus_sclk}), 64'd3);
      chk(done_cnt == 0, "R9 no done after abort", 64'(done_cnt), 64'd0);
      chk(rd_data == prev_rd, "R9 read data unchanged by abort", 64'(rd_data), 64'(prev_rd));
      launch(8'h3E, 1'b1, 2, 32'h0000BEEF, 32'h0);
      finish_check(8'h3E, 1'b1, 2, 32'h0000BEEF, 32'h0, prev_rd, 1'b1);

      // R9 abort while idle
      repeat (OFF + 5) @(negedge clk);
      done_cnt = 0;
      abort = 1'b1;
      @(negedge clk);
      abort = 1'b0;
      chk(bus_csn == 1'b1 && req_ready == 1'b1 && bus_sclk == 1'b1, "R9 idle abort has no effect",
          64'({bus_csn, req_ready, bus_sclk}), 64'd7);
      chk(done_cnt == 0 && rd_data == prev_rd, "R9 idle abort keeps done and data", 64'(done_cnt), 64'd0);

      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

endmodule